// File: doc/BRIEF.md
# Saturating Transmit Event Tally

This block keeps four small transmit statistics counters side by side in one read-only word. Every time the transmit path finishes a packet it pulses a completion strobe and, in the same cycle, reports how many collisions the packet met and whether it was deferred or deferred for too long. Each counter moves by at most one per packet, however many times its event happened during that packet's retries.

Each counter stops at its all-ones value instead of wrapping. While any counter sits at that value a level interrupt is raised. Reading the word returns all four counts and clears them together. The read is meant to be done from the transmit service routine, so statistics stay complete even when successful transmissions raise no interrupt of their own.

Top module: `txev_tally`

## Requirements
- R1: After reset `rd_data` is 0 and `irq` is low.
- R2: A completion pulse with `coll_cnt` equal to 1 adds one to the single-collision field `rd_data[3:0]`, and to no other collision field.
- R3: A completion pulse with `coll_cnt` from 2 to 16 adds one to the multiple-collision field `rd_data[7:4]`. A `coll_cnt` of 0 or above 16 touches neither collision field.
- R4: A completion pulse with `deferred` high adds one to the deferred field `rd_data[11:8]`, once per packet.
- R5: A completion pulse with `excess_defer` high adds one to the excessive-deferral field `rd_data[15:12]`, once per packet.
- R6: Without a completion pulse the qualifiers have no effect, and each field changes by at most one per clock.
- R7: A field at 15 stays at 15 on further qualifying packets. Neighbouring fields are unaffected.
- R8: `irq` is high exactly while at least one field equals 15.
- R9: A cycle with `rd_stb` high presents the old counts on `rd_data`. After that edge each field is 0, or 1 if the same cycle carried a qualifying packet for it, and `irq` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | One-cycle pulse: a transmit packet has completed |
| coll_cnt | input | 5 | Collisions met by the completed packet (0 to 31) |
| deferred | input | 1 | The completed packet was deferred at least once |
| excess_defer | input | 1 | The completed packet was deferred excessively |
| rd_stb | input | 1 | Read strobe; clears all fields at the clock edge |
| rd_data | output | 16 | Packed counts: [15:12] excess, [11:8] deferred, [7:4] multiple, [3:0] single |
| irq | output | 1 | Level interrupt, high while any field is 15 |

## Verification
A completion pulse sampled at a rising edge shows up in `rd_data` and `irq` right after that edge, with no further register stage. The bench therefore drives each stimulus on a falling edge and checks one falling edge later. For a read, `rd_data` is sampled before the clearing edge to get the old counts and again after it to get the restarted values. The bench sweeps all 128 combinations of collision count and both deferral flags against arithmetic expectations. It then drives the fields into saturation, checks the interrupt, and overlaps a read with a packet.

// File: rtl/txev_tally.sv
module txev_tally #(
  parameter int FW        = 4,
  parameter int CW        = 5,
  parameter int MULTI_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_done,
  input  logic [CW-1:0]     coll_cnt,
  input  logic              deferred,
  input  logic              excess_defer,
  input  logic              rd_stb,
  output logic [4*FW-1:0]   rd_data,
  output logic              irq
);
  localparam int NF = 4;
  localparam logic [FW-1:0] TOP = '1;

  logic [NF-1:0][FW-1:0] cnt;
  logic [NF-1:0]         hit;
  logic [NF-1:0]         sat;

  assign hit[0] = pkt_done && (coll_cnt == CW'(1));
  assign hit[1] = pkt_done && (coll_cnt >= CW'(2)) && (coll_cnt <= CW'(MULTI_MAX));
  assign hit[2] = pkt_done && deferred;
  assign hit[3] = pkt_done && excess_defer;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[i] <= '0;
      else if (rd_stb)
        cnt[i] <= FW'(hit[i]);
      else if (hit[i] && cnt[i] != TOP)
        cnt[i] <= cnt[i] + FW'(1);
    end
    assign sat[i] = (cnt[i] == TOP);
  end

  assign rd_data = cnt;
  assign irq     = |sat;
endmodule

module txev_tally_chk #(
  parameter int FW = 4,
  parameter int CW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pkt_done,
  input logic [CW-1:0]   coll_cnt,
  input logic            deferred,
  input logic            excess_defer,
  input logic            rd_stb,
  input logic [4*FW-1:0] rd_data,
  input logic            irq
);
  localparam logic [FW-1:0] TOP = '1;

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_done && !rd_stb) |=> $stable(rd_data));

  a_r9_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !pkt_done) |=> (rd_data == '0 && !irq));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && coll_cnt == CW'(1) && !rd_stb && rd_data[FW-1:0] != TOP)
      |=> rd_data[FW-1:0] == $past(rd_data[FW-1:0]) + FW'(1));

  for (genvar i = 0; i < 4; i++) begin : g_chk
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[i*FW +: FW] == TOP && !rd_stb) |=> rd_data[i*FW +: FW] == TOP);
    a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> (rd_data[i*FW +: FW] - $past(rd_data[i*FW +: FW])) <= FW'(1));
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> rd_data[i*FW +: FW] <= FW'(1));
  end
endmodule

bind txev_tally txev_tally_chk #(.FW(FW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .coll_cnt(coll_cnt),
  .deferred(deferred), .excess_defer(excess_defer), .rd_stb(rd_stb),
  .rd_data(rd_data), .irq(irq)
);

// File: tb/txev_tally_test.sv
module txev_tally_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pkt_done = 0;
  logic [4:0]  coll_cnt = '0;
  logic        deferred = 0;
  logic        excess_defer = 0;
  logic        rd_stb = 0;
  logic [15:0] rd_data;
  logic        irq;
  int tests = 0;
  int fails = 0;

  txev_tally uut (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .coll_cnt(coll_cnt),
    .deferred(deferred), .excess_defer(excess_defer), .rd_stb(rd_stb),
    .rd_data(rd_data), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic pd, input logic [4:0] c, input logic d,
                     input logic e, input logic rd);
    pkt_done = pd; coll_cnt = c; deferred = d; excess_defer = e; rd_stb = rd;
    @(negedge clk);
    pkt_done = 0; coll_cnt = '0; deferred = 0; excess_defer = 0; rd_stb = 0;
  endtask

  function automatic logic [15:0] expv(int c, logic d, logic e);
    return {3'b0, e, 3'b0, d, 3'b0, (c >= 2 && c <= 16) ? 1'b1 : 1'b0,
            3'b0, (c == 1) ? 1'b1 : 1'b0};
  endfunction

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset data", rd_data, 16'h0);
    chk("R1 reset irq", {15'b0, irq}, 16'h0);

    // R2 R3 R4 R5 sweep
    for (int c = 0; c < 32; c++)
      for (int k = 0; k < 4; k++) begin
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
        cyc(1'b1, 5'(c), k[0], k[1], 1'b0);
        chk($sformatf("R2/R3/R4/R5 coll=%0d d=%0d e=%0d", c, k[0], k[1]),
            rd_data, expv(c, k[0], k[1]));
      end

    // R6 qualifiers without completion pulse
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 5'd1, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 5'd5, 1'b1, 1'b1, 1'b0);
    chk("R6 no pulse no change", rd_data, 16'h0);

    // R7 R8 saturation
    for (int n = 1; n <= 20; n++) begin
      cyc(1'b1, 5'd1, 1'b1, 1'b0, 1'b0);
      if (n == 14) begin
        chk("R8 irq low below 15", {15'b0, irq}, 16'h0);
        chk("R2 count 14", rd_data, 16'h0E0E);
      end
      if (n == 15) chk("R8 irq at 15", {15'b0, irq}, 16'h1);
    end
    chk("R7 saturated", rd_data, 16'h0F0F);
    chk("R8 irq held", {15'b0, irq}, 16'h1);
    cyc(1'b1, 5'd9, 1'b0, 1'b1, 1'b0);
    chk("R7 neighbours move", rd_data, 16'h1F1F);

    // R9 read with simultaneous packet
    chk("R9 old value before edge", rd_data, 16'h1F1F);
    cyc(1'b1, 5'd3, 1'b1, 1'b0, 1'b1);
    chk("R9 restart from pending", rd_data, 16'h0110);
    chk("R9 irq dropped", {15'b0, irq}, 16'h0);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
    chk("R9 plain read clears", rd_data, 16'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule